// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Control Register

This block is the transmit half of an asynchronous serial port. Software sees an 8-bit control register. It holds four interrupt enables, a transmitter enable, a receiver enable, a receiver wake bit and a break bit. The receiver enable and the receiver wake bit are only stored. Bytes come in on a valid/ready stream and land in a one-entry holding buffer. From there they move into a shift register that drives the serial line. The line rests at logic 1.

Each time the transmitter enable turns on, the block first sends one frame-length run of 1s as a preamble. Turning the enable off lets the frame on the line finish. Turning it off and back on while a frame is in flight queues one all-ones idle frame right behind that frame. While the break bit is set, the block sends all-zero frames.

Two masked interrupt lines combine the enables with status:
- The transmit interrupt uses the buffer-empty and line-done flags.
- The receive interrupt uses two flags that arrive as inputs from a receiver outside this block.

A baud tick input, at 16 ticks per bit, paces the line.

Top module: `sci_tx_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is 1, `in_ready` and `tx_done` are 1, and both interrupt outputs are 0.
- R2: A write on `cfg_wr` stores `cfg_wdata` in the control register, and the new value reads back on `cfg_rdata` from the next cycle. The bit map is:
  - bit 7: empty interrupt enable
  - bit 6: done interrupt enable
  - bit 5: receive-full interrupt enable
  - bit 4: receive-idle interrupt enable
  - bit 3: transmitter enable
  - bit 2: receiver enable (stored only)
  - bit 1: receiver wake (stored only)
  - bit 0: break
- R3: `tx_irq` = (bit7 & `tx_empty`) | (bit6 & `tx_done`), and `rx_irq` = (bit5 & `rx_full`) | (bit4 & `rx_idle`). Both are combinational in the same cycle.
- R4: A data frame has the following shape, and `txd` does not change in a cycle with no baud tick:
  - one start bit of 0
  - 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1), sent LSB first; `in_data[8]` is ignored in 8-bit mode
  - one stop bit of 1
  - each bit lasts 16 baud ticks
- R5: When bit 3 rises, a preamble of all 1s is sent first. It lasts 10 bit times in 8-bit mode and 11 in 9-bit mode. With baud ticks every cycle, `tx_done` is low for 16·N+1 cycles, where N is the frame length in bits.
- R6: `in_ready` (equal to `tx_empty`) is 1 while the holding buffer is empty. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low from the next cycle and rises again in the cycle the byte moves into the shift register. Queued frames follow one another with no gap.
- R7: `tx_done` is 1 only when the shift register is idle and no enabled preamble, break or buffered data is waiting. With bit 3 clear, `tx_done` ignores the buffer.
- R8: Clearing bit 3 lets the frame on the line finish, after which `txd` stays at 1. A buffered byte is then held and not sent until bit 3 is set again.
- R9: Clearing and then setting bit 3 during a frame inserts one all-ones frame. The next data frame therefore starts 2·N·16 cycles after the current one.
- R10: While bits 3 and 0 are both set, whole all-zero frames (start, data and stop all 0) are sent ahead of buffered data. With bit 3 clear, bit 0 has no effect on `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| in_valid | input | 1 | Stream data valid |
| in_data | input | 9 | Stream data character |
| in_ready | output | 1 | Holding buffer can accept |
| rx_full | input | 1 | Receiver data-full flag |
| rx_idle | input | 1 | Receiver idle-line flag |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Transmission complete flag |
| tx_irq | output | 1 | Masked transmitter interrupt |
| rx_irq | output | 1 | Masked receiver interrupt |

## Verification
Each result has a fixed latency:
- A register write is visible on `cfg_rdata` one cycle after its edge.
- The interrupt outputs follow their inputs in the same cycle.
- `in_ready` falls one cycle after an accepted byte.
- A frame's first bit appears on the edge after the request that starts it.

The bench drives and samples on falling edges. It counts `tx_done` low cycles to measure preamble length. It decodes the line at mid-bit points (8, then every 16 cycles after the start edge) and compares frame start times, which exposes inserted idle frames.

// File: rtl/sci_tx_pkg.sv
package sci_tx_pkg;
  localparam int CR_BRK      = 0;
  localparam int CR_RX_WAKE  = 1;
  localparam int CR_RX_EN    = 2;
  localparam int CR_TX_EN    = 3;
  localparam int CR_IDLE_IE  = 4;
  localparam int CR_RXF_IE   = 5;
  localparam int CR_DONE_IE  = 6;
  localparam int CR_EMPTY_IE = 7;

  typedef enum logic [1:0] {
    FK_ONES = 2'd0,
    FK_ZERO = 2'd1,
    FK_DATA = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/sci_ctrl_reg.sv
module sci_ctrl_reg
  import sci_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl,
  input  logic       tx_empty,
  input  logic       tx_done,
  input  logic       rx_full,
  input  logic       rx_idle,
  output logic       tx_irq,
  output logic       rx_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl <= '0;
    else if (wr_en) ctrl <= wr_data;
  end

  assign tx_irq = (ctrl[CR_EMPTY_IE] & tx_empty) | (ctrl[CR_DONE_IE] & tx_done);
  assign rx_irq = (ctrl[CR_RXF_IE] & rx_full) | (ctrl[CR_IDLE_IE] & rx_idle);

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |-> (ctrl == $past(wr_data))); // R2
endmodule

// File: rtl/sci_tx_sched.sv
module sci_tx_sched
  import sci_tx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                brk,
  input  logic                in_valid,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                in_ready,
  input  logic                sh_free,
  input  logic                sh_busy,
  output logic                ld,
  output frame_kind_e         ld_kind,
  output logic [DATA_MAX-1:0] ld_data,
  output logic                tx_done
);
  logic                full;
  logic [DATA_MAX-1:0] hold;
  logic                en_d;
  logic                ones_pend;
  logic                want_ones;
  logic                accept;

  assign in_ready  = ~full;
  assign accept    = in_valid & ~full;
  assign want_ones = ones_pend | (tx_en & ~en_d);
  assign ld_data   = hold;

  // Priority: queued all-ones frame, then break, then buffered data.
  always_comb begin
    ld      = 1'b0;
    ld_kind = FK_DATA;
    if (tx_en && sh_free) begin
      if (want_ones) begin
        ld      = 1'b1;
        ld_kind = FK_ONES;
      end else if (brk) begin
        ld      = 1'b1;
        ld_kind = FK_ZERO;
      end else if (full) begin
        ld      = 1'b1;
        ld_kind = FK_DATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d      <= 1'b0;
      ones_pend <= 1'b0;
      full      <= 1'b0;
      hold      <= '0;
    end else begin
      en_d <= tx_en;
      if (!tx_en) ones_pend <= 1'b0;
      else        ones_pend <= want_ones & ~(ld & (ld_kind == FK_ONES));
      if (accept) begin
        full <= 1'b1;
        hold <= in_data;
      end else if (ld && ld_kind == FK_DATA) begin
        full <= 1'b0;
      end
    end
  end

  assign tx_done = ~sh_busy & ~(tx_en & (want_ones | brk | full));
endmodule

// File: rtl/sci_tx_shift.sv
module sci_tx_shift
  import sci_tx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int OVS      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                nine_bit,
  input  logic                ld,
  input  frame_kind_e         ld_kind,
  input  logic [DATA_MAX-1:0] ld_data,
  output logic                txd,
  output logic                busy,
  output logic                free
);
  localparam int FW = DATA_MAX + 2;
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] left;
  logic [FW-1:0] frame;
  logic [BW-1:0] flen;
  logic          bit_end;

  assign bit_end = busy & baud_tick & (tcnt == CW'(OVS - 1));
  assign free    = ~busy | (bit_end & (left == BW'(1)));
  assign flen    = nine_bit ? BW'(FW) : BW'(FW - 1);

  always_comb begin
    frame = '1;
    case (ld_kind)
      FK_ZERO: frame = '0;
      FK_DATA: begin
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
          if (i < DATA_MAX - 1 || nine_bit) frame[i+1] = ld_data[i];
        end
      end
      default: frame = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      tcnt <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (ld) begin
      sh   <= frame;
      tcnt <= '0;
      left <= flen;
      busy <= 1'b1;
    end else if (busy && baud_tick) begin
      tcnt <= bit_end ? '0 : tcnt + CW'(1);
      if (bit_end) begin
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - BW'(1);
        if (left == BW'(1)) busy <= 1'b0;
      end
    end
  end

  assign txd = busy ? sh[0] : 1'b1;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(txd)); // R4
endmodule

// File: rtl/sci_tx_ctrl.sv
module sci_tx_ctrl
  import sci_tx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int OVS      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                nine_bit,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic                in_valid,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                in_ready,
  input  logic                rx_full,
  input  logic                rx_idle,
  output logic                txd,
  output logic                tx_empty,
  output logic                tx_done,
  output logic                tx_irq,
  output logic                rx_irq
);
  logic [7:0]          ctrl;
  logic                sh_free, sh_busy, ld;
  frame_kind_e         ld_kind;
  logic [DATA_MAX-1:0] ld_data;

  assign cfg_rdata = ctrl;
  assign tx_empty  = in_ready;

  sci_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_data(cfg_wdata), .ctrl(ctrl),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full), .rx_idle(rx_idle),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  sci_tx_sched #(.DATA_MAX(DATA_MAX)) u_sched (
    .clk(clk), .rst_n(rst_n), .tx_en(ctrl[CR_TX_EN]), .brk(ctrl[CR_BRK]),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sh_free(sh_free), .sh_busy(sh_busy), .ld(ld), .ld_kind(ld_kind),
    .ld_data(ld_data), .tx_done(tx_done)
  );

  sci_tx_shift #(.DATA_MAX(DATA_MAX), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .nine_bit(nine_bit),
    .ld(ld), .ld_kind(ld_kind), .ld_data(ld_data),
    .txd(txd), .busy(sh_busy), .free(sh_free)
  );

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_busy) |-> $past(ctrl[CR_TX_EN])); // R8
  AST_DRAIN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> sh_busy); // R6
  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd); // R7
endmodule

// File: tb/sim_sci_tx_ctrl.sv
module sim_sci_tx_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1, nine_bit = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready, rx_full = 1'b0, rx_idle = 1'b0;
  logic       txd, tx_empty, tx_done, tx_irq, rx_irq;

  sci_tx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .nine_bit(nine_bit),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rx_full(rx_full), .rx_idle(rx_idle), .txd(txd), .tx_empty(tx_empty),
    .tx_done(tx_done), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [8:0] got_d [64];
  logic       got_s [64];
  int         got_t [64];
  int         got_n = 0;

  // Line decoder: mid-bit sampling from the start edge.
  initial begin : dec
    logic [8:0] d;
    logic       st;
    int         nb, t0;
    @(negedge clk);
    forever begin
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      nb = nine_bit ? 9 : 8;
      d  = '0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
        repeat (16) @(negedge clk);
        d[i] = txd;
      end
      repeat (16) @(negedge clk);
      st = txd;
      if (got_n < 64) begin
        got_d[got_n] = d;
        got_s[got_n] = st;
        got_t[got_n] = t0;
        got_n = got_n + 1;
      end
      repeat (8) @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6", "ready after accept", int'(in_ready), 0);
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tx_done && n < 5000);
  endtask

  task automatic measure_pre(input int nbits);
    int lows = 0, zeros = 0;
    while (!tx_done && lows < 1000) begin
      lows++;
      if (!txd) zeros++;
      @(negedge clk);
    end
    chk(lows == 16*nbits + 1, "R5", "preamble done-low cycles", lows, 16*nbits + 1);
    chk(zeros == 0, "R5", "preamble zero samples", zeros, 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int base, n;
    logic [7:0] vb;
    logic       et, er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1", "ctrl reset", int'(cfg_rdata), 0);
    chk(txd == 1'b1, "R1", "txd reset", int'(txd), 1);
    chk(in_ready == 1'b1, "R1", "ready reset", int'(in_ready), 1);
    chk(tx_done == 1'b1, "R1", "done reset", int'(tx_done), 1);
    chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R1", "irqs reset", int'({tx_irq, rx_irq}), 0);

    // R2/R3 sweep with transmitter off, buffer empty then full
    for (int f = 0; f < 2; f++) begin
      if (f == 1) push(9'h03C);
      for (int v = 0; v < 256; v++) begin
        vb = 8'(v);
        if (vb[3]) continue;
        wr(vb);
        chk(cfg_rdata == vb, "R2", "readback", int'(cfg_rdata), int'(vb));
        for (int r = 0; r < 4; r++) begin
          rx_full = r[0];
          rx_idle = r[1];
          #1;
          et = (vb[7] & (f == 0)) | vb[6];
          er = (vb[5] & r[0]) | (vb[4] & r[1]);
          chk(tx_irq == et, "R3", "tx_irq mask", int'(tx_irq), int'(et));
          chk(rx_irq == er, "R3", "rx_irq mask", int'(rx_irq), int'(er));
        end
        chk(txd == 1'b1, "R10", "break ignored while disabled", int'(txd), 1);
      end
    end
    rx_full = 1'b0;
    rx_idle = 1'b0;

    // Enable: preamble then the held byte
    base = got_n;
    wr(8'h08);
    wait_done();
    chk(got_n == base + 1, "R4", "frames after enable", got_n - base, 1);
    chk(got_d[base] == 9'h03C && got_s[base] == 1'b1, "R4", "held byte frame", int'(got_d[base]), 'h3C);
    chk(in_ready == 1'b1, "R6", "buffer drained", int'(in_ready), 1);

    // R5 preamble length, both modes
    for (int m = 0; m < 2; m++) begin
      nine_bit = m[0];
      wr(8'h00);
      wr(8'h08);
      measure_pre(10 + m);
    end

    // R4/R6 9-bit back-to-back stream
    base = got_n;
    push(9'h1A5);
    chk(tx_done == 1'b0, "R7", "done low while sending", int'(tx_done), 0);
    push(9'h05A);
    push(9'h100);
    wait_done();
    chk(got_n == base + 3, "R6", "frame count", got_n - base, 3);
    chk(got_d[base] == 9'h1A5 && got_s[base], "R4", "9-bit frame 0", int'(got_d[base]), 'h1A5);
    chk(got_d[base+1] == 9'h05A && got_s[base+1], "R4", "9-bit frame 1", int'(got_d[base+1]), 'h05A);
    chk(got_d[base+2] == 9'h100 && got_s[base+2], "R4", "9-bit frame 2", int'(got_d[base+2]), 'h100);
    chk(got_t[base+1] - got_t[base] == 176, "R6", "no gap spacing", got_t[base+1] - got_t[base], 176);
    chk(tx_done == 1'b1, "R7", "done when idle", int'(tx_done), 1);

    // R8 clear enable mid-frame, 8-bit mode
    nine_bit = 1'b0;
    base = got_n;
    push(9'h196);
    repeat (50) @(negedge clk);
    wr(8'h00);
    push(9'h011);
    wait_done();
    chk(got_d[base] == 9'h096 && got_s[base], "R8", "frame finishes", int'(got_d[base]), 'h96);
    chk(got_d[base] != 9'h196, "R4", "bit 8 ignored", int'(got_d[base]), 'h96);
    n = got_n;
    repeat (300) @(negedge clk);
    chk(got_n == n, "R8", "no frame while disabled", got_n - n, 0);
    chk(txd == 1'b1, "R8", "line idle while disabled", int'(txd), 1);
    chk(in_ready == 1'b0, "R8", "byte held", int'(in_ready), 0);
    wr(8'h08);
    wait_done();
    chk(got_d[got_n-1] == 9'h011, "R8", "held byte sent after re-enable", int'(got_d[got_n-1]), 'h11);

    // R9 toggle during a frame queues an idle frame
    base = got_n;
    push(9'h055);
    push(9'h0AA);
    wr(8'h00);
    wr(8'h08);
    wait_done();
    chk(got_n == base + 2, "R9", "two data frames", got_n - base, 2);
    chk(got_d[base] == 9'h055 && got_d[base+1] == 9'h0AA, "R9", "data order", int'(got_d[base+1]), 'hAA);
    chk(got_t[base+1] - got_t[base] == 320, "R9", "idle frame inserted", got_t[base+1] - got_t[base], 320);

    // R10 break frames ahead of data
    base = got_n;
    wr(8'h09);
    push(9'h07E);
    repeat (400) @(negedge clk);
    wr(8'h08);
    wait_done();
    n = got_n - base;
    chk(n >= 3, "R10", "break frames plus data", n, 3);
    for (int i = 0; i < n - 1; i++)
      chk(got_d[base+i] == 9'h000 && got_s[base+i] == 1'b0, "R10", "all-zero frame", int'({got_s[base+i], got_d[base+i]}), 0);
    chk(got_d[got_n-1] == 9'h07E && got_s[got_n-1], "R10", "data after break", int'(got_d[got_n-1]), 'h7E);

    // R4 no baud ticks: line holds the start bit
    baud_tick = 1'b0;
    push(9'h001);
    repeat (100) @(negedge clk);
    chk(txd == 1'b0, "R4", "start bit held without ticks", int'(txd), 0);
    chk(in_ready == 1'b1, "R6", "byte moved to shifter", int'(in_ready), 1);
    chk(tx_done == 1'b0, "R7", "done low while stalled", int'(tx_done), 0);
    baud_tick = 1'b1;
    wait_done();
    chk(tx_done == 1'b1 && txd == 1'b1, "R7", "idle after stall", int'(tx_done), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule